// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the bus cycles that take an 8-bit processor core into an exception handler and back out again. It handles five entries and exits: the software break instruction, the non-maskable interrupt, the maskable interrupt, the power-on reset and the return-from-interrupt instruction. For each entry it pushes the return address and the status onto a stack that lives in a fixed page. It then reads a 16-bit vector, low byte first, and hands the core a new program counter, stack pointer and status together with a one-cycle done strobe. For a return it pops the status and the address back.

The core pulses `brk_i` or `rti_i` during the opcode fetch cycle of those instructions. It raises `boundary_i` between instructions so that the block can decide whether a pending interrupt must be taken. The non-maskable request is edge-latched inside the block. When a request of that kind is pending as the status byte of a break or maskable entry is pushed, it takes over the vector fetch. The stacked status still shows how the entry began. Every bus cycle reads `rdata_i` in the same cycle as the address it drives. The core's state is held in the block from the start strobe until the done strobe.

Top module: `vector_seq`

## Requirements
- R1: After reset is released the block runs a 7-cycle start-up entry on its own: two reads at address 0x0000, three stack reads with no write while the stack pointer steps down from 0x00, then the vector reads. The result is PC = vector, SP = 0xFD, status = 0x24. `done_o` and `we_o` stay low while reset is held.
- R2: A break or interrupt entry writes the return address high byte to stack page address {0x01, SP}, then the low byte at SP-1, then the status at SP-2. The reported SP is the input SP minus 3.
- R3: The stacked status has bit 5 set. Bit 4 (break) is 1 for a break entry and 0 for a maskable or non-maskable entry.
- R4: Vectors are read low byte first: non-maskable from 0xFFFA/0xFFFB, start-up from 0xFFFC/0xFFFD, maskable and break from 0xFFFE/0xFFFF.
- R5: Every entry reports a status with bit 2 (interrupt disable) set, bit 5 set and bit 4 clear. The other bits are passed through.
- R6: If the non-maskable request is pending when the status byte of a break or maskable entry is pushed, the vector comes from 0xFFFA/0xFFFB and the request is consumed. The stacked status keeps the break bit of the original entry.
- R7: A non-maskable edge that is first sampled on the clock edge that ends the status push does not change that entry's vector. It stays pending and is taken at the next instruction boundary.
- R8: A return reads PC, then the stack at SP, then pops the status from SP+1, the PC low byte from SP+2 and the PC high byte from SP+3. It reports SP+3 and the popped status with bit 5 set and bit 4 clear.
- R9: Stack addresses wrap within the stack page when pushing and when popping (SP 0x00 - 1 = 0xFF, 0xFF + 1 = 0x00).
- R10: A non-maskable request is taken once per falling edge of `nmi_n_i` and wins over a maskable request. A low `irq_n_i` is serviced at a boundary only when `p_i` bit 2 is 0; otherwise the boundary starts nothing.
- R11: `done_o` is a single-cycle pulse. Counting rising edges from the cycle that presents the start strobe, it appears after 7 edges for a break, 8 for an interrupt and 6 for a return.
- R12: A break first makes one read at `pc_i` and stacks `pc_i`+1. An interrupt makes two reads at `pc_i` and stacks `pc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released in step with the clock |
| brk_i | input | 1 | Break opcode fetched this cycle |
| rti_i | input | 1 | Return opcode fetched this cycle |
| boundary_i | input | 1 | Core is between instructions; a pending interrupt may start |
| nmi_n_i | input | 1 | Non-maskable request, active on a falling edge |
| irq_n_i | input | 1 | Maskable request, active low level |
| pc_i | input | 16 | Core PC at the start strobe (address after the opcode) |
| sp_i | input | 8 | Core stack pointer at the start strobe |
| p_i | input | 8 | Core status at the start strobe |
| rdata_i | input | 8 | Read data for the address driven this cycle |
| addr_o | output | 16 | Bus address |
| we_o | output | 1 | 1 for a write cycle, 0 for a read |
| wdata_o | output | 8 | Write data, 0 on reads |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Single-cycle strobe: results valid |
| pc_o | output | 16 | Resulting program counter |
| sp_o | output | 8 | Resulting stack pointer |
| p_o | output | 8 | Resulting status |

## Verification
The first bus cycle shows up one edge after the start strobe is sampled. Each later bus cycle follows one edge after the one before it, so the bench queues the whole expected address, direction and data trace before it strobes. It then compares one entry at every falling clock edge while `busy_o` is high. The done strobe is due 7, 8 or 6 rising edges after the strobe cycle for a break, an interrupt or a return. It is due 7 edges after reset release for the start-up entry. The bench stamps each queued result with the edge count at the strobe and checks that distance when `done_o` appears. The take-over window is tested at its edge: a non-maskable drop two falling edges after the break is sampled is taken over, and a drop one edge later is left pending.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  localparam int DW = 8;
  localparam int AW = 16;

  // status bit masks
  localparam logic [DW-1:0] P_IMASK = 8'h04;
  localparam logic [DW-1:0] P_BRKB  = 8'h10;
  localparam logic [DW-1:0] P_ONE   = 8'h20;

  localparam logic [DW-1:0] D_ONE = 8'd1;
  localparam logic [AW-1:0] A_ONE = 16'd1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DUM0,
    ST_DUM1,
    ST_PSH_H,
    ST_PSH_L,
    ST_PSH_P,
    ST_VLO,
    ST_VHI,
    ST_RSTK,
    ST_PUL_P,
    ST_PUL_L,
    ST_PUL_H
  } seq_state_e;

  typedef enum logic [2:0] {
    K_BRK,
    K_IRQ,
    K_NMI,
    K_RST,
    K_RTI
  } seq_kind_e;

endpackage

// File: rtl/vseq_nmi_latch.sv
module vseq_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_n_i,
  input  logic clr_i,
  output logic pend_o
);

  logic lvl_q;
  logic pend_q;
  logic pend_d;
  logic fall;

  // a high-to-low change between two samples is a new request
  assign fall = lvl_q & ~nmi_n_i;

  // a fresh edge wins over a clear in the same cycle
  always_comb begin
    pend_d = fall | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= nmi_n_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter logic [AW-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [AW-1:0] VEC_RST = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ = 16'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          brk_i,
  input  logic          rti_i,
  input  logic          boundary_i,
  input  logic          irq_n_i,
  input  logic          nmi_pend_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] p_i,
  input  logic [DW-1:0] rdata_i,
  output seq_state_e    state_o,
  output seq_kind_e     kind_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] vec_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] p_o,
  output logic          nmi_clr_o,
  output logic          done_o
);

  seq_state_e    state_q, state_d;
  seq_kind_e     kind_q, kind_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [AW-1:0] vec_q, vec_d;
  logic [DW-1:0] sp_q, sp_d;
  logic [DW-1:0] p_q, p_d;
  logic [DW-1:0] lo_q, lo_d;
  logic          done_q, done_d;
  logic          start;
  logic          ld_en;
  logic          clr;

  // next-state process
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    pc_d    = pc_q;
    vec_d   = vec_q;
    sp_d    = sp_q;
    p_d     = p_q;
    lo_d    = lo_q;
    done_d  = 1'b0;
    start   = 1'b0;
    clr     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rti_i) begin
          start   = 1'b1;
          kind_d  = K_RTI;
          state_d = ST_DUM1;
        end else if (brk_i) begin
          start   = 1'b1;
          kind_d  = K_BRK;
          vec_d   = VEC_IRQ;
          state_d = ST_DUM1;
        end else if (boundary_i && nmi_pend_i) begin
          start   = 1'b1;
          clr     = 1'b1;
          kind_d  = K_NMI;
          vec_d   = VEC_NMI;
          state_d = ST_DUM0;
        end else if (boundary_i && !irq_n_i && ((p_i & P_IMASK) == '0)) begin
          start   = 1'b1;
          kind_d  = K_IRQ;
          vec_d   = VEC_IRQ;
          state_d = ST_DUM0;
        end
        if (start) begin
          pc_d = pc_i;
          sp_d = sp_i;
          p_d  = p_i;
        end
      end
      ST_DUM0: state_d = ST_DUM1;
      ST_DUM1: state_d = (kind_q == K_RTI) ? ST_RSTK : ST_PSH_H;
      ST_PSH_H: begin
        sp_d    = sp_q - D_ONE;
        state_d = ST_PSH_L;
      end
      ST_PSH_L: begin
        sp_d    = sp_q - D_ONE;
        state_d = ST_PSH_P;
      end
      ST_PSH_P: begin
        sp_d    = sp_q - D_ONE;
        p_d     = (p_q | P_IMASK | P_ONE) & ~P_BRKB;
        state_d = ST_VLO;
        // late take-over of the vector by a pending non-maskable request
        if ((kind_q == K_BRK || kind_q == K_IRQ) && nmi_pend_i) begin
          vec_d = VEC_NMI;
          clr   = 1'b1;
        end
      end
      ST_VLO: begin
        lo_d    = rdata_i;
        state_d = ST_VHI;
      end
      ST_VHI: begin
        pc_d    = {rdata_i, lo_q};
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_RSTK: begin
        sp_d    = sp_q + D_ONE;
        state_d = ST_PUL_P;
      end
      ST_PUL_P: begin
        p_d     = (rdata_i | P_ONE) & ~P_BRKB;
        sp_d    = sp_q + D_ONE;
        state_d = ST_PUL_L;
      end
      ST_PUL_L: begin
        lo_d    = rdata_i;
        sp_d    = sp_q + D_ONE;
        state_d = ST_PUL_H;
      end
      ST_PUL_H: begin
        pc_d    = {rdata_i, lo_q};
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ld_en = (state_q != ST_IDLE) | start;

  // register process; reset lands in the start-up entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DUM0;
      kind_q  <= K_RST;
      pc_q    <= '0;
      vec_q   <= VEC_RST;
      sp_q    <= '0;
      p_q     <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (ld_en) begin
        kind_q <= kind_d;
        pc_q   <= pc_d;
        vec_q  <= vec_d;
        sp_q   <= sp_d;
        p_q    <= p_d;
        lo_q   <= lo_d;
      end
    end
  end

  assign state_o   = state_q;
  assign kind_o    = kind_q;
  assign pc_o      = pc_q;
  assign vec_o     = vec_q;
  assign sp_o      = sp_q;
  assign p_o       = p_q;
  assign nmi_clr_o = clr;
  assign done_o    = done_q;

endmodule

// File: rtl/vseq_bus.sv
module vseq_bus
  import vseq_pkg::*;
#(
  parameter logic [DW-1:0] STK_PAGE = 8'h01
) (
  input  seq_state_e    state_i,
  input  seq_kind_e     kind_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] vec_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] p_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o
);

  logic [AW-1:0] stk_addr;
  logic [AW-1:0] ret;
  logic          push_we;

  assign stk_addr = {STK_PAGE, sp_i};
  assign ret      = pc_i + ((kind_i == K_BRK) ? A_ONE : '0);
  // the start-up entry walks the stack without writing
  assign push_we  = (kind_i != K_RST);

  always_comb begin
    addr_o  = pc_i;
    we_o    = 1'b0;
    wdata_o = '0;
    unique case (state_i)
      ST_IDLE, ST_DUM0, ST_DUM1: addr_o = pc_i;
      ST_PSH_H: begin
        addr_o  = stk_addr;
        we_o    = push_we;
        wdata_o = push_we ? ret[AW-1:DW] : '0;
      end
      ST_PSH_L: begin
        addr_o  = stk_addr;
        we_o    = push_we;
        wdata_o = push_we ? ret[DW-1:0] : '0;
      end
      ST_PSH_P: begin
        addr_o = stk_addr;
        we_o   = push_we;
        if (!push_we)
          wdata_o = '0;
        else if (kind_i == K_BRK)
          wdata_o = p_i | P_BRKB | P_ONE;
        else
          wdata_o = (p_i | P_ONE) & ~P_BRKB;
      end
      ST_VLO: addr_o = vec_i;
      ST_VHI: addr_o = vec_i + A_ONE;
      ST_RSTK, ST_PUL_P, ST_PUL_L, ST_PUL_H: addr_o = stk_addr;
      default: addr_o = pc_i;
    endcase
  end

endmodule

// File: rtl/vector_seq.sv
module vector_seq
  import vseq_pkg::*;
#(
  parameter logic [DW-1:0] STK_PAGE = 8'h01,
  parameter logic [AW-1:0] VEC_NMI  = 16'hFFFA,
  parameter logic [AW-1:0] VEC_RST  = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ  = 16'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          brk_i,
  input  logic          rti_i,
  input  logic          boundary_i,
  input  logic          nmi_n_i,
  input  logic          irq_n_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] p_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] p_o
);

  seq_state_e    state;
  seq_kind_e     kind;
  logic [AW-1:0] pc_r;
  logic [AW-1:0] vec_r;
  logic [DW-1:0] sp_r;
  logic [DW-1:0] p_r;
  logic          nmi_pend;
  logic          nmi_clr;

  vseq_nmi_latch i_nmi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nmi_n_i (nmi_n_i),
    .clr_i   (nmi_clr),
    .pend_o  (nmi_pend)
  );

  vseq_ctrl #(
    .VEC_NMI (VEC_NMI),
    .VEC_RST (VEC_RST),
    .VEC_IRQ (VEC_IRQ)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .brk_i      (brk_i),
    .rti_i      (rti_i),
    .boundary_i (boundary_i),
    .irq_n_i    (irq_n_i),
    .nmi_pend_i (nmi_pend),
    .pc_i       (pc_i),
    .sp_i       (sp_i),
    .p_i        (p_i),
    .rdata_i    (rdata_i),
    .state_o    (state),
    .kind_o     (kind),
    .pc_o       (pc_r),
    .vec_o      (vec_r),
    .sp_o       (sp_r),
    .p_o        (p_r),
    .nmi_clr_o  (nmi_clr),
    .done_o     (done_o)
  );

  vseq_bus #(
    .STK_PAGE (STK_PAGE)
  ) i_bus (
    .state_i (state),
    .kind_i  (kind),
    .pc_i    (pc_r),
    .vec_i   (vec_r),
    .sp_i    (sp_r),
    .p_i     (p_r),
    .addr_o  (addr_o),
    .we_o    (we_o),
    .wdata_o (wdata_o)
  );

  assign busy_o = (state != ST_IDLE);
  assign pc_o   = pc_r;
  assign sp_o   = sp_r;
  assign p_o    = p_r;

endmodule

// File: rtl/vseq_chk.sv
module vseq_chk
  import vseq_pkg::*;
#(
  parameter logic [DW-1:0] STK_PAGE = 8'h01
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_o,
  input logic          we_o,
  input logic [DW-1:0] wdata_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] sp_o,
  input logic [DW-1:0] p_o
);

  // R2
  stack_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> addr_o[AW-1:DW] == STK_PAGE);

  // R9
  push_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> sp_o == $past(sp_o) - D_ONE);

  // R3
  status_u_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(we_o) && $past(we_o, 2)) |-> (wdata_o & P_ONE) != '0);

  // R5
  entry_iflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(we_o) && $past(we_o, 2)) |=> (p_o & P_IMASK) != '0);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

endmodule

bind vector_seq vseq_chk #(
  .STK_PAGE (STK_PAGE)
) i_vseq_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_o  (addr_o),
  .we_o    (we_o),
  .wdata_o (wdata_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sp_o    (sp_o),
  .p_o     (p_o)
);

// File: tb/test_vector_seq.sv
`timescale 1ns/1ps
module test_vector_seq;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        brk_i, rti_i, boundary_i, nmi_n_i, irq_n_i;
  logic [15:0] pc_i;
  logic [7:0]  sp_i, p_i, rdata_i;
  logic [15:0] addr_o;
  logic        we_o, busy_o, done_o;
  logic [7:0]  wdata_o, sp_o, p_o;
  logic [15:0] pc_o;

  always #2 clk_i = ~clk_i;

  vector_seq i_vector_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .brk_i(brk_i), .rti_i(rti_i),
    .boundary_i(boundary_i), .nmi_n_i(nmi_n_i), .irq_n_i(irq_n_i),
    .pc_i(pc_i), .sp_i(sp_i), .p_i(p_i), .rdata_i(rdata_i),
    .addr_o(addr_o), .we_o(we_o), .wdata_o(wdata_o), .busy_o(busy_o),
    .done_o(done_o), .pc_o(pc_o), .sp_o(sp_o), .p_o(p_o)
  );

  typedef struct {
    logic [15:0] a;
    logic        w;
    logic [7:0]  d;
    string       tag;
  } bus_t;

  typedef struct {
    logic [15:0] pc;
    logic [7:0]  sp;
    logic [7:0]  p;
    int          lat;
    int          t0;
    string       tag;
  } res_t;

  bus_t bus_q[$];
  res_t res_q[$];
  logic [7:0] stk [256];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // memory model: vectors, stack page, filler elsewhere
  always_comb begin
    case (addr_o)
      16'hFFFA: rdata_i = 8'h11;
      16'hFFFB: rdata_i = 8'h90;
      16'hFFFC: rdata_i = 8'h22;
      16'hFFFD: rdata_i = 8'h80;
      16'hFFFE: rdata_i = 8'h33;
      16'hFFFF: rdata_i = 8'hA0;
      default:  rdata_i = (addr_o[15:8] == 8'h01) ? stk[addr_o[7:0]] : (addr_o[7:0] ^ 8'hA5);
    endcase
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic exp_bus(input logic [15:0] a, input logic w, input logic [7:0] d, input string tag);
    bus_t b;
    b.a = a; b.w = w; b.d = d; b.tag = tag;
    bus_q.push_back(b);
  endtask

  task automatic exp_res(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p,
                         input int lat, input int t0, input string tag);
    res_t r;
    r.pc = pc; r.sp = sp; r.p = p; r.lat = lat; r.t0 = t0; r.tag = tag;
    res_q.push_back(r);
  endtask

  // monitor: one bus entry per busy cycle, one result per done pulse
  always @(negedge clk_i) begin : mon
    bus_t b;
    res_t r;
    if (rst_ni === 1'b1) begin
      if (busy_o) begin
        if (bus_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected bus cycle", {15'd0, we_o, addr_o}, 32'd0);
        end else begin
          b = bus_q.pop_front();
          chk(addr_o == b.a && we_o == b.w && (!b.w || wdata_o == b.d), b.tag, "bus cycle",
              {7'd0, we_o, addr_o, (we_o ? wdata_o : 8'h00)},
              {7'd0, b.w, b.a, (b.w ? b.d : 8'h00)});
        end
        if (we_o) stk[addr_o[7:0]] = wdata_o;
      end
      if (done_o) begin
        n_done++;
        if (res_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected done", {16'd0, pc_o}, 32'd0);
        end else begin
          r = res_q.pop_front();
          chk(pc_o == r.pc, r.tag, "pc_o", {16'd0, pc_o}, {16'd0, r.pc});
          chk(sp_o == r.sp, r.tag, "sp_o", {24'd0, sp_o}, {24'd0, r.sp});
          chk(p_o == r.p, "R5", "p_o", {24'd0, p_o}, {24'd0, r.p});
          chk(cyc - r.t0 == r.lat, "R11", "done latency", cyc - r.t0, r.lat);
        end
      end
    end
  end

  task automatic wait_idle();
    while (bus_q.size() != 0 || res_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_brk(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p,
                        input int nmi_k, input bit hijack, input string tag);
    logic [15:0] ret;
    logic [15:0] vec;
    int t0;
    ret = pc + 16'd1;
    vec = hijack ? 16'hFFFA : 16'hFFFE;
    exp_bus(pc, 1'b0, 8'h00, "R12");
    exp_bus({8'h01, sp}, 1'b1, ret[15:8], {"R2 ", tag});
    exp_bus({8'h01, sp - 8'd1}, 1'b1, ret[7:0], {"R2 ", tag});
    exp_bus({8'h01, sp - 8'd2}, 1'b1, p | 8'h30, {"R3 ", tag});
    exp_bus(vec, 1'b0, 8'h00, hijack ? "R6" : {"R4 ", tag});
    exp_bus(vec + 16'd1, 1'b0, 8'h00, hijack ? "R6" : {"R4 ", tag});
    @(negedge clk_i);
    t0 = cyc;
    exp_res(hijack ? 16'h9011 : 16'hA033, sp - 8'd3, (p | 8'h24) & ~8'h10, 7, t0, {"R2 ", tag});
    pc_i = pc; sp_i = sp; p_i = p; brk_i = 1'b1;
    @(negedge clk_i);
    brk_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (k == nmi_k) nmi_n_i = 1'b0;
      @(negedge clk_i);
    end
    wait_idle();
  endtask

  task automatic do_int(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p,
                        input bit nmi, input string tag);
    logic [15:0] vec;
    int t0;
    vec = nmi ? 16'hFFFA : 16'hFFFE;
    exp_bus(pc, 1'b0, 8'h00, "R12");
    exp_bus(pc, 1'b0, 8'h00, "R12");
    exp_bus({8'h01, sp}, 1'b1, pc[15:8], {"R2 ", tag});
    exp_bus({8'h01, sp - 8'd1}, 1'b1, pc[7:0], {"R2 ", tag});
    exp_bus({8'h01, sp - 8'd2}, 1'b1, (p | 8'h20) & ~8'h10, {"R3 ", tag});
    exp_bus(vec, 1'b0, 8'h00, {"R4 ", tag});
    exp_bus(vec + 16'd1, 1'b0, 8'h00, {"R4 ", tag});
    @(negedge clk_i);
    t0 = cyc;
    exp_res(nmi ? 16'h9011 : 16'hA033, sp - 8'd3, (p | 8'h24) & ~8'h10, 8, t0, tag);
    pc_i = pc; sp_i = sp; p_i = p; boundary_i = 1'b1;
    @(negedge clk_i);
    boundary_i = 1'b0;
    wait_idle();
  endtask

  task automatic do_rti(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] pv,
                        input logic [7:0] lo, input logic [7:0] hi, input string tag);
    int t0;
    stk[sp + 8'd1] = pv;
    stk[sp + 8'd2] = lo;
    stk[sp + 8'd3] = hi;
    exp_bus(pc, 1'b0, 8'h00, "R8");
    exp_bus({8'h01, sp}, 1'b0, 8'h00, "R8");
    exp_bus({8'h01, sp + 8'd1}, 1'b0, 8'h00, {"R8 ", tag});
    exp_bus({8'h01, sp + 8'd2}, 1'b0, 8'h00, {"R8 ", tag});
    exp_bus({8'h01, sp + 8'd3}, 1'b0, 8'h00, {"R8 ", tag});
    @(negedge clk_i);
    t0 = cyc;
    exp_res({hi, lo}, sp + 8'd3, (pv | 8'h20) & ~8'h10, 6, t0, {"R8 ", tag});
    pc_i = pc; sp_i = sp; p_i = 8'h00; rti_i = 1'b1;
    @(negedge clk_i);
    rti_i = 1'b0;
    wait_idle();
  endtask

  task automatic do_none(input logic [7:0] p, input string tag);
    int n0;
    @(negedge clk_i);
    n0 = n_done;
    p_i = p; boundary_i = 1'b1;
    @(negedge clk_i);
    boundary_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk(busy_o == 1'b0 && n_done == n0, tag, "no service expected",
        (n_done - n0) + int'(busy_o), 32'd0);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : drv
    int t0;
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    rst_ni = 1'b0;
    brk_i = 1'b0; rti_i = 1'b0; boundary_i = 1'b0;
    nmi_n_i = 1'b1; irq_n_i = 1'b1;
    pc_i = 16'h0000; sp_i = 8'h00; p_i = 8'h00;
    repeat (3) @(negedge clk_i);
    // R1: quiet outputs while reset is held
    chk(done_o == 1'b0 && we_o == 1'b0, "R1", "outputs in reset", {30'd0, done_o, we_o}, 32'd0);

    // R1 R9: start-up entry walks 0x0100, 0x01FF, 0x01FE without writing
    exp_bus(16'h0000, 1'b0, 8'h00, "R1");
    exp_bus(16'h0000, 1'b0, 8'h00, "R1");
    exp_bus(16'h0100, 1'b0, 8'h00, "R1");
    exp_bus(16'h01FF, 1'b0, 8'h00, "R9");
    exp_bus(16'h01FE, 1'b0, 8'h00, "R9");
    exp_bus(16'hFFFC, 1'b0, 8'h00, "R4");
    exp_bus(16'hFFFD, 1'b0, 8'h00, "R4");
    @(posedge clk_i);
    #1;
    t0 = cyc;
    exp_res(16'h8022, 8'hFD, 8'h24, 7, t0, "R1");
    rst_ni = 1'b1;
    wait_idle();

    // R2 R3 R4 R12: plain break
    do_brk(16'h1234, 8'hFD, 8'h00, -1, 1'b0, "plain");
    // R9: push wraps from 0x0100 to 0x01FF
    do_brk(16'h40FF, 8'h01, 8'hC3, -1, 1'b0, "R9");
    // R8 R9: return pops across the page wrap
    do_rti(16'h4000, 8'hFE, 8'hDB, 8'h78, 8'h56, "R9");

    // R10: maskable entry when enabled
    irq_n_i = 1'b0;
    do_int(16'h2000, 8'hF0, 8'h00, 1'b0, "R10");
    // R10: masked by status bit 2
    do_none(8'h04, "R10");

    // R10: non-maskable wins over a pending maskable request
    @(negedge clk_i);
    nmi_n_i = 1'b0;
    repeat (2) @(negedge clk_i);
    do_int(16'h3456, 8'h80, 8'h01, 1'b1, "R10");
    irq_n_i = 1'b1;
    // R10: a held-low line is not a new request
    do_none(8'h00, "R10");
    nmi_n_i = 1'b1;
    repeat (2) @(negedge clk_i);

    // R6: request seen before the status push takes over the vector
    do_brk(16'h5000, 8'hC0, 8'h81, 2, 1'b1, "R6");
    // R6: the request was consumed
    do_none(8'h00, "R6");
    nmi_n_i = 1'b1;
    repeat (2) @(negedge clk_i);

    // R7: request first sampled at the end of the status push stays pending
    do_brk(16'h6000, 8'hA0, 8'h00, 3, 1'b0, "R7");
    do_int(16'h6002, 8'h9D, 8'h00, 1'b1, "R7");
    nmi_n_i = 1'b1;
    repeat (4) @(negedge clk_i);

    chk(bus_q.size() == 0 && res_q.size() == 0, "R11", "leftover expectations",
        bus_q.size() + res_q.size(), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule